// File: doc/BRIEF.md
# Indirect Byte-Register Access Bridge

This block sits between a host that sees a single 64-bit command/status word and the small set of 8-bit registers that configure a two-wire serial controller. The host never addresses those byte registers directly. Instead it writes one word that carries several fields: a busy flag, an operation code, a three-bit register selector, a direction flag and a data byte. The bridge decodes the word and performs the byte access a fixed number of cycles later. It then drops the busy flag in the same word. For a read, it also leaves the fetched byte in the low byte of that word. The host polls the word until the flag is clear.

The byte registers sit inside the bridge: data, control, clock-control, clock half-period and status. Their values go out to the serial controller, which can also load the status register and the data register through a narrow update port. One selector decodes to a different register depending on direction. Writing it sets the clock-control byte. Reading it returns the status byte. A write to the reset selector puts the status back to its idle value and pulses a reset strobe toward the controller.

Top module: `sercsr_bridge`

## Requirements
- R1: After reset the command word reads 0, the data, control and clock-control outputs are 0x00, the half-period output is 0x18 and the status register holds 0xF8.
- R2: A host write with bit 63 set while bit 63 of the word is clear stores the word. Bit 63 then reads 1 for exactly 2 cycles and clears on the second clock edge after the launching edge.
- R3: A host write that arrives while bit 63 of the word is set is ignored. The pending command completes unchanged.
- R4: Bit 56 clear means write. With bits 62:57 equal to 6 (top byte 0x0C), selector bits 34:32 pick the data register (1), the control register (2) or the clock-control register (3). With bits 62:57 equal to 4 (top byte 0x08), selector 0 picks the half-period register. The register takes bits 7:0 at the completion edge and at no other time.
- R5: Bit 56 set means read. At completion, bits 7:0 of the word are replaced by the fetched byte and bits 62:8 keep their value. An extended read of selector 3 returns the status register, not the clock-control register.
- R6: An extended write to selector 7 sets the status register to 0xF8 and raises the reset strobe for exactly one cycle, the cycle just after completion.
- R7: A selector or operation code outside R4, R5 and R6 completes normally with no register change, and a read of it returns 0x00. This includes an extended read of selector 7 and top byte 0x0A.
- R8: The controller update port loads the status register or the data register at the next clock edge. A host access to the same register that completes at the same edge takes priority.
- R9: A host write with bit 63 clear while idle stores the word but starts no access. Bit 63 stays 0 and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe for the command word |
| host_wr_word | input | 64 | Command word written by the host |
| host_rd_word | output | 64 | Current command/status word |
| ctrl_stat_we | input | 1 | Controller loads the status register |
| ctrl_stat_val | input | 8 | New status value |
| ctrl_rx_we | input | 1 | Controller loads the data register |
| ctrl_rx_val | input | 8 | Received byte |
| data_o | output | 8 | Data register |
| ctl_o | output | 8 | Control register |
| clkctl_o | output | 8 | Clock-control register |
| halfper_o | output | 8 | Clock half-period register |
| soft_rst_o | output | 1 | One-cycle reset strobe toward the controller |

## Verification
The main function is exercised with writes to every decodable target, each followed by a read-back. These patterns show whether the decode sends each selector to its own register and whether bits outside the low byte survive completion. A write to selector 3 followed by a read of selector 3 shows whether reads and writes resolve to different registers. Unknown selectors, an unknown operation code and a read of the reset selector show whether anything outside the map changes state or returns non-zero. A second write during a busy window, a write with the flag clear, and a controller load that coincides with a host completion cover arbitration and launch gating.

// File: rtl/sercsr_pkg.sv
// Shared field positions, operation codes and target encoding for the
// indirect byte-register bridge. Assumes a 64-bit command word.
package sercsr_pkg;
    localparam int WORD_W     = 64;
    localparam int BYTE_W     = 8;
    localparam int VALID_BIT  = 63;
    localparam int READ_BIT   = 56;
    localparam int OP_HI      = 62;
    localparam int OP_LO      = 57;
    localparam int OP_W       = OP_HI - OP_LO + 1;
    localparam int SEL_HI     = 34;
    localparam int SEL_LO     = 32;
    localparam int SEL_W      = SEL_HI - SEL_LO + 1;

    localparam logic [OP_W-1:0]   OP_EXT      = 6'h06;
    localparam logic [OP_W-1:0]   OP_DIRECT   = 6'h04;
    localparam logic [SEL_W-1:0]  SEL_DATA    = 3'd1;
    localparam logic [SEL_W-1:0]  SEL_CTL     = 3'd2;
    localparam logic [SEL_W-1:0]  SEL_CLKSTAT = 3'd3;
    localparam logic [SEL_W-1:0]  SEL_RESET   = 3'd7;
    localparam logic [SEL_W-1:0]  SEL_HALFPER = 3'd0;
    localparam logic [BYTE_W-1:0] IDLE_STATUS = 8'hF8;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_DATA,
        TGT_CTL,
        TGT_CLKCTL,
        TGT_STATUS,
        TGT_HALFPER,
        TGT_RESET
    } tgt_e;
endpackage

// File: rtl/sercsr_decode.sv
// Decodes the command word into a byte-register target.
// Assumes the word is stable while bit 63 is set. Purely combinational.
module sercsr_decode
    import sercsr_pkg::*;
(
    input  logic [WORD_W-1:0] cmd_word,
    output tgt_e              tgt,
    output logic              is_read
);
    logic [OP_W-1:0]  op;
    logic [SEL_W-1:0] sel;

    assign op      = cmd_word[OP_HI:OP_LO];
    assign sel     = cmd_word[SEL_HI:SEL_LO];
    assign is_read = cmd_word[READ_BIT];

    // Map operation code, selector and direction to one target.
    always_comb begin
        tgt = TGT_NONE;
        if (op == OP_EXT) begin
            case (sel)
                SEL_DATA:    tgt = TGT_DATA;
                SEL_CTL:     tgt = TGT_CTL;
                SEL_CLKSTAT: tgt = is_read ? TGT_STATUS : TGT_CLKCTL;
                SEL_RESET:   tgt = is_read ? TGT_NONE : TGT_RESET;
                default:     tgt = TGT_NONE;
            endcase
        end else if (op == OP_DIRECT) begin
            if (sel == SEL_HALFPER) tgt = TGT_HALFPER;
        end
    end
endmodule

// File: rtl/sercsr_seq.sv
// Holds the host command word and times each access.
// Assumes LATENCY >= 1. A launch is a host write with bit 63 set while
// bit 63 is clear. Completion comes LATENCY edges later. While busy,
// host writes are dropped.
module sercsr_seq
    import sercsr_pkg::*;
#(
    parameter int LATENCY = 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [WORD_W-1:0] host_wr_word,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [WORD_W-1:0] cmd_word,
    output logic              acc_fire
);
    localparam int CNT_W = $clog2(LATENCY) + 1;
    localparam logic [CNT_W-1:0] LAT_LAST = CNT_W'(LATENCY - 1);

    logic [CNT_W-1:0] lat_cnt;
    logic             busy;

    assign busy     = cmd_word[VALID_BIT];
    assign acc_fire = busy && (lat_cnt == LAT_LAST);

    // Load, age and retire the command word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_word <= '0;
            lat_cnt  <= '0;
        end else if (busy) begin
            if (acc_fire) begin
                cmd_word[VALID_BIT] <= 1'b0;
                if (cmd_word[READ_BIT]) cmd_word[BYTE_W-1:0] <= rd_byte;
                lat_cnt <= '0;
            end else begin
                lat_cnt <= lat_cnt + 1'b1;
            end
        end else if (host_wr_en) begin
            cmd_word <= host_wr_word;
            lat_cnt  <= '0;
        end
    end
endmodule

// File: rtl/sercsr_regbank.sv
// The byte registers behind the bridge, with a read multiplexer.
// Assumes acc_fire lasts one cycle per access. A host write that
// completes wins over a controller load at the same edge.
module sercsr_regbank
    import sercsr_pkg::*;
#(
    parameter logic [BYTE_W-1:0] HALFPER_RST = 8'h18
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_fire,
    input  logic              acc_read,
    input  tgt_e              tgt,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              ctrl_stat_we,
    input  logic [BYTE_W-1:0] ctrl_stat_val,
    input  logic              ctrl_rx_we,
    input  logic [BYTE_W-1:0] ctrl_rx_val,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] data_q,
    output logic [BYTE_W-1:0] ctl_q,
    output logic [BYTE_W-1:0] clkctl_q,
    output logic [BYTE_W-1:0] halfper_q,
    output logic              soft_rst_q
);
    logic [BYTE_W-1:0] status_q;
    logic              wr_hit;

    assign wr_hit = acc_fire && !acc_read;

    // Data register: host write first, then controller receive load.
    always_ff @(posedge clk) begin
        if (!rst_n)                          data_q <= '0;
        else if (wr_hit && tgt == TGT_DATA)  data_q <= wbyte;
        else if (ctrl_rx_we)                 data_q <= ctrl_rx_val;
    end

    // Control register: host writes only.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ctl_q <= '0;
        else if (wr_hit && tgt == TGT_CTL)   ctl_q <= wbyte;
    end

    // Clock-control register: host writes only.
    always_ff @(posedge clk) begin
        if (!rst_n)                            clkctl_q <= '0;
        else if (wr_hit && tgt == TGT_CLKCTL)  clkctl_q <= wbyte;
    end

    // Clock half-period register: host writes only.
    always_ff @(posedge clk) begin
        if (!rst_n)                             halfper_q <= HALFPER_RST;
        else if (wr_hit && tgt == TGT_HALFPER)  halfper_q <= wbyte;
    end

    // Status register: soft reset first, then controller updates.
    always_ff @(posedge clk) begin
        if (!rst_n)                           status_q <= IDLE_STATUS;
        else if (wr_hit && tgt == TGT_RESET)  status_q <= IDLE_STATUS;
        else if (ctrl_stat_we)                status_q <= ctrl_stat_val;
    end

    // One-cycle strobe after a completed soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) soft_rst_q <= 1'b0;
        else        soft_rst_q <= wr_hit && (tgt == TGT_RESET);
    end

    // Read multiplexer. Unmapped targets read as zero.
    always_comb begin
        case (tgt)
            TGT_DATA:    rd_byte = data_q;
            TGT_CTL:     rd_byte = ctl_q;
            TGT_STATUS:  rd_byte = status_q;
            TGT_HALFPER: rd_byte = halfper_q;
            default:     rd_byte = '0;
        endcase
    end
endmodule

// File: rtl/sercsr_bridge.sv
// Top of the bridge: one self-clearing command word in front of a bank
// of byte registers. Assumes one host writer that polls bit 63.
module sercsr_bridge
    import sercsr_pkg::*;
#(
    parameter int                LATENCY     = 2,
    parameter logic [BYTE_W-1:0] HALFPER_RST = 8'h18
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [WORD_W-1:0] host_wr_word,
    output logic [WORD_W-1:0] host_rd_word,
    input  logic              ctrl_stat_we,
    input  logic [BYTE_W-1:0] ctrl_stat_val,
    input  logic              ctrl_rx_we,
    input  logic [BYTE_W-1:0] ctrl_rx_val,
    output logic [BYTE_W-1:0] data_o,
    output logic [BYTE_W-1:0] ctl_o,
    output logic [BYTE_W-1:0] clkctl_o,
    output logic [BYTE_W-1:0] halfper_o,
    output logic              soft_rst_o
);
    logic [WORD_W-1:0] cmd_word;
    logic [BYTE_W-1:0] rd_byte;
    logic              acc_fire;
    logic              acc_read;
    tgt_e              tgt;

    sercsr_seq #(.LATENCY(LATENCY)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_en   (host_wr_en),
        .host_wr_word (host_wr_word),
        .rd_byte      (rd_byte),
        .cmd_word     (cmd_word),
        .acc_fire     (acc_fire)
    );

    sercsr_decode u_dec (
        .cmd_word (cmd_word),
        .tgt      (tgt),
        .is_read  (acc_read)
    );

    sercsr_regbank #(.HALFPER_RST(HALFPER_RST)) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_fire      (acc_fire),
        .acc_read      (acc_read),
        .tgt           (tgt),
        .wbyte         (cmd_word[BYTE_W-1:0]),
        .ctrl_stat_we  (ctrl_stat_we),
        .ctrl_stat_val (ctrl_stat_val),
        .ctrl_rx_we    (ctrl_rx_we),
        .ctrl_rx_val   (ctrl_rx_val),
        .rd_byte       (rd_byte),
        .data_q        (data_o),
        .ctl_q         (ctl_o),
        .clkctl_q      (clkctl_o),
        .halfper_q     (halfper_o),
        .soft_rst_q    (soft_rst_o)
    );

    assign host_rd_word = cmd_word;
endmodule

// File: rtl/sercsr_bridge_chk.sv
// Port-level checks for the bridge, attached by bind.
// Busy windows are measured with a counter, not a deep $past.
module sercsr_bridge_chk #(
    parameter int LATENCY = 2
)(
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr_en,
    input logic [63:0] host_rd_word,
    input logic [7:0]  ctl_o,
    input logic [7:0]  clkctl_o,
    input logic [7:0]  halfper_o,
    input logic        soft_rst_o
);
    logic [15:0] busy_len;

    // Count consecutive busy cycles of the command word.
    always_ff @(posedge clk) begin
        if (!rst_n)                busy_len <= '0;
        else if (!host_rd_word[63]) busy_len <= '0;
        else if (busy_len != 16'hFFFF) busy_len <= busy_len + 1'b1;
    end

    assert_busy_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_word[63] |-> (busy_len < 16'(LATENCY)));

    assert_busy_full_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_rd_word[63]) |-> (busy_len == 16'(LATENCY)));

    assert_busy_write_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_word[63] && host_wr_en) |=> (host_rd_word[62:8] == $past(host_rd_word[62:8])));

    assert_ctl_only_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_o) |-> $fell(host_rd_word[63]));

    assert_clkctl_only_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clkctl_o) |-> $fell(host_rd_word[63]));

    assert_halfper_only_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(halfper_o) |-> $fell(host_rd_word[63]));

    assert_reset_strobe_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> $fell(host_rd_word[63]));

    assert_reset_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o);
endmodule

bind sercsr_bridge sercsr_bridge_chk #(.LATENCY(LATENCY)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_en   (host_wr_en),
    .host_rd_word (host_rd_word),
    .ctl_o        (ctl_o),
    .clkctl_o     (clkctl_o),
    .halfper_o    (halfper_o),
    .soft_rst_o   (soft_rst_o)
);

// File: tb/tb_sercsr_bridge.sv
// Scoreboard bench: the driver queues the expected completion word,
// the monitor pops it when bit 63 falls.
module tb_sercsr_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;
    localparam logic [5:0] EXT = 6'h06;
    localparam logic [5:0] DIR = 6'h04;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [63:0] host_wr_word = '0;
    logic [63:0] host_rd_word;
    logic        ctrl_stat_we = 1'b0;
    logic [7:0]  ctrl_stat_val = '0;
    logic        ctrl_rx_we = 1'b0;
    logic [7:0]  ctrl_rx_val = '0;
    logic [7:0]  data_o, ctl_o, clkctl_o, halfper_o;
    logic        soft_rst_o;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    int run_len = 0;
    logic prev_v = 1'b0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    logic [7:0] m_data, m_ctl, m_clkctl, m_halfper, m_status;

    sercsr_bridge dut (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_word(host_wr_word),
        .host_rd_word(host_rd_word), .ctrl_stat_we(ctrl_stat_we), .ctrl_stat_val(ctrl_stat_val),
        .ctrl_rx_we(ctrl_rx_we), .ctrl_rx_val(ctrl_rx_val), .data_o(data_o), .ctl_o(ctl_o),
        .clkctl_o(clkctl_o), .halfper_o(halfper_o), .soft_rst_o(soft_rst_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [5:0] op, input logic rd,
                                       input logic [2:0] sel, input logic [7:0] d);
        return {1'b1, op, rd, 21'h0, sel, 24'hA5C300, d};
    endfunction

    function automatic logic [7:0] model_read(input logic [63:0] w);
        if (w[62:57] == EXT) begin
            case (w[34:32])
                3'd1: return m_data;
                3'd2: return m_ctl;
                3'd3: return m_status;
                default: return 8'h00;
            endcase
        end else if (w[62:57] == DIR && w[34:32] == 3'd0) return m_halfper;
        return 8'h00;
    endfunction

    task automatic model_apply(input logic [63:0] w);
        if (!w[56]) begin
            if (w[62:57] == EXT) begin
                case (w[34:32])
                    3'd1: m_data   = w[7:0];
                    3'd2: m_ctl    = w[7:0];
                    3'd3: m_clkctl = w[7:0];
                    3'd7: m_status = 8'hF8;
                    default: ;
                endcase
            end else if (w[62:57] == DIR && w[34:32] == 3'd0) m_halfper = w[7:0];
        end
    endtask

    task automatic push_exp(input logic [63:0] w, input string req);
        exp_q.push_back(w[56] ? {1'b0, w[62:8], model_read(w)} : {1'b0, w[62:0]});
        tag_q.push_back(req);
        model_apply(w);
    endtask

    task automatic chk_regs(input string req);
        chk(req, "data_o",    {56'h0, data_o},    {56'h0, m_data});
        chk(req, "ctl_o",     {56'h0, ctl_o},     {56'h0, m_ctl});
        chk(req, "clkctl_o",  {56'h0, clkctl_o},  {56'h0, m_clkctl});
        chk(req, "halfper_o", {56'h0, halfper_o}, {56'h0, m_halfper});
    endtask

    // Launch one command and wait until it has completed and settled.
    task automatic run_cmd(input logic [63:0] w, input string req);
        push_exp(w, req);
        @(negedge clk); host_wr_en = 1'b1; host_wr_word = w;
        @(negedge clk); host_wr_en = 1'b0;
        repeat (4) @(negedge clk);
        chk_regs(req);
    endtask

    // Monitor: compare each completion with the queue and its busy length.
    always @(negedge clk) begin
        if (rst_n) begin
            if (soft_rst_o) strobes++;
            if (host_rd_word[63]) run_len++;
            if (prev_v && !host_rd_word[63]) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 unexpected completion: actual 0x%0h expected none", host_rd_word);
                end else begin
                    chk(tag_q.pop_front(), "completion word", host_rd_word, exp_q.pop_front());
                    chk("R2", "busy cycles", 64'(run_len), 64'(LAT));
                end
                run_len = 0;
            end
            prev_v = host_rd_word[63];
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_data = 8'h00; m_ctl = 8'h00; m_clkctl = 8'h00; m_halfper = 8'h18; m_status = 8'hF8;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        chk("R1", "word", host_rd_word, 64'h0);
        chk_regs("R1");
        run_cmd(mk(EXT, 1'b1, 3'd3, 8'h00), "R1");           // status reads 0xF8

        // R4: writes to each target
        run_cmd(mk(EXT, 1'b0, 3'd1, 8'h5A), "R4");
        run_cmd(mk(EXT, 1'b0, 3'd2, 8'h44), "R4");
        run_cmd(mk(EXT, 1'b0, 3'd3, 8'h13), "R4");
        run_cmd(mk(DIR, 1'b0, 3'd0, 8'h2B), "R4");

        // R5: read-backs; selector 3 read gives status, not clock-control
        run_cmd(mk(EXT, 1'b1, 3'd2, 8'h77), "R5");
        run_cmd(mk(EXT, 1'b1, 3'd3, 8'h00), "R5");
        run_cmd(mk(EXT, 1'b1, 3'd1, 8'h00), "R5");
        run_cmd(mk(DIR, 1'b1, 3'd0, 8'hFF), "R5");

        // R8: controller loads, seen through host reads
        @(negedge clk); ctrl_stat_we = 1'b1; ctrl_stat_val = 8'h08;
        ctrl_rx_we = 1'b1; ctrl_rx_val = 8'h9C;
        @(negedge clk); ctrl_stat_we = 1'b0; ctrl_rx_we = 1'b0;
        m_status = 8'h08; m_data = 8'h9C;
        chk("R8", "data_o after rx load", {56'h0, data_o}, 64'h9C);
        run_cmd(mk(EXT, 1'b1, 3'd3, 8'h00), "R8");

        // R6: soft reset restores idle status and strobes once
        strobes = 0;
        run_cmd(mk(EXT, 1'b0, 3'd7, 8'h00), "R6");
        chk("R6", "strobe count", 64'(strobes), 64'd1);
        run_cmd(mk(EXT, 1'b1, 3'd3, 8'h00), "R6");

        // R7: unmapped selectors and opcode
        run_cmd(mk(EXT, 1'b0, 3'd5, 8'hC3), "R7");
        run_cmd(mk(EXT, 1'b1, 3'd5, 8'hC3), "R7");
        run_cmd(mk(EXT, 1'b1, 3'd7, 8'h11), "R7");
        run_cmd(mk(6'h05, 1'b1, 3'd1, 8'h22), "R7");
        run_cmd(mk(DIR, 1'b0, 3'd2, 8'h66), "R7");

        // R3: a second write during the busy window is dropped
        push_exp(mk(EXT, 1'b0, 3'd2, 8'h11), "R3");
        @(negedge clk); host_wr_en = 1'b1; host_wr_word = mk(EXT, 1'b0, 3'd2, 8'h11);
        @(negedge clk); host_wr_word = mk(EXT, 1'b0, 3'd1, 8'h77);
        @(negedge clk); host_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        chk_regs("R3");

        // R9: flag clear stores the word, starts nothing
        @(negedge clk); host_wr_en = 1'b1; host_wr_word = {1'b0, EXT, 1'b0, 21'h0, 3'd2, 24'h0, 8'hE1};
        @(negedge clk); host_wr_en = 1'b0;
        chk("R9", "stored word", host_rd_word, {1'b0, EXT, 1'b0, 21'h0, 3'd2, 24'h0, 8'hE1});
        repeat (4) @(negedge clk);
        chk("R9", "word still idle", {63'h0, host_rd_word[63]}, 64'h0);
        chk_regs("R9");

        // R8: host completion and controller load at the same edge
        push_exp(mk(EXT, 1'b0, 3'd1, 8'h31), "R8");
        @(negedge clk); host_wr_en = 1'b1; host_wr_word = mk(EXT, 1'b0, 3'd1, 8'h31);
        @(negedge clk); host_wr_en = 1'b0;
        @(negedge clk); ctrl_rx_we = 1'b1; ctrl_rx_val = 8'hEE;
        @(negedge clk); ctrl_rx_we = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8", "host wins data", {56'h0, data_o}, 64'h31);

        repeat (3) @(negedge clk);
        chk("R2", "queue drained", 64'(exp_q.size()), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule